// File: doc/BRIEF.md
# Write-Only Serial Control Register Slave

This block is a two-wire serial (I2C) target that lets a host load a bank of twelve 8-bit control registers. Both bus lines are sampled by the system clock. The block detects start and stop conditions and checks the target address byte. It then takes register-address and data bytes and writes each data byte into the register that the preceding address byte selected. All registers are presented at once on a flat parallel bus for downstream control logic. There is no read-back path.

One transaction may carry any number of address-plus-data pairs after a single start and target address. The register pointer never advances by itself, so every data byte needs its own address byte. Addresses outside the implemented range are acknowledged and dropped. Reset loads a fixed default into every register. The block drives SDA only through an open-drain enable, and only during acknowledge bits.

Top module: `i2cw_slave`

## Requirements
- R1: After reset every register holds its default. Addresses 1, 3, 4 and 5 hold 180 (0xB4). Addresses 6, 10, 11 and 12 hold 0x80. Addresses 2, 7, 8 and 9 hold 0x00. Register address a (1..12) appears on regs_o[(a-1)*8 +: 8].
- R2: An address byte of 0xDC (7-bit address 0x6E, direction bit 0) after a start is acknowledged: sda_oe is 1 while SCL is high in the ninth clock.
- R3: If the address byte differs from 0xDC, including 0xDD (direction bit 1), sda_oe stays 0 and no register changes until the next start.
- R4: After a matched address, the register-address byte and the data byte are each acknowledged, and the data byte is written to the addressed register.
- R5: Every byte is shifted in MSB first.
- R6: Several address-plus-data pairs may follow one start and one address byte. Each data byte goes to the address sent just before it, with no auto-increment.
- R7: A data byte aimed at address 0 or at an address of 13 or above is acknowledged, and all register outputs stay unchanged.
- R8: Register address 7 holds only 4 bits. Bits [7:4] of it read as 0 whatever data is written.
- R9: A start seen in the middle of a byte aborts that byte, and the new transaction proceeds normally. A stop ends the transaction, and a register address sent without its data byte causes no write.
- R10: sda_oe rises only after a falling SCL edge, and it is 0 once a stop has been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset; loads register defaults |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 (acknowledge); otherwise released |
| regs_o | output | 96 | All twelve registers, address 1 in the low byte |

## Verification
The bench targets the cases an off-by-one decoder gets wrong. A slave that advanced its pointer would corrupt register 11 after the multi-pair write. One that shifted LSB first would turn 0x12 into 0x48. One that ignored the direction bit would acknowledge 0xDD and accept the bytes that follow it. A start placed three bits into a data byte must leave the target register untouched while the following transaction lands, which exposes a bit counter that is not cleared. A stop right after a register address must not cause a write. The bench also checks that a write to an unimplemented address is still acknowledged and leaves the whole output bus intact, and that writing 0xFF to the narrow register reads back as 0x0F.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int REG_W      = 8;
  localparam int N_REGS     = 12;
  localparam int FIRST_ADDR = 1;
  localparam int NARROW_IDX = 6;   // address 7
  localparam int NARROW_W   = 4;

  typedef enum logic [1:0] {S_IDLE, S_RX, S_ACK} bus_state_t;
  typedef enum logic [1:0] {P_DEV, P_REG, P_DAT} byte_phase_t;

  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0, 2, 3, 4:    reg_default = 8'd180;
      5, 9, 10, 11:  reg_default = 8'h80;
      default:       reg_default = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cw_regbank.sv
module i2cw_regbank
  import i2cw_pkg::*;
#(
  parameter int N   = 12,
  parameter int W   = 8,
  parameter int NIX = 6,
  parameter int NW  = 4,
  localparam int IDXW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [W-1:0]    wr_data,
  output logic [N*W-1:0]  regs_o
);
  localparam logic [W-1:0] NMASK = W'((1 << NW) - 1);

  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] keep;
    if (g == NIX) begin : g_narrow
      always_ff @(posedge clk) begin
        if (rst)                                  keep <= W'(reg_default(g)) & NMASK;
        else if (wr_en && wr_idx == IDXW'(g))      keep <= wr_data & NMASK;
      end
    end else begin : g_full
      always_ff @(posedge clk) begin
        if (rst)                                  keep <= W'(reg_default(g));
        else if (wr_en && wr_idx == IDXW'(g))      keep <= wr_data;
      end
    end
    assign regs_o[g*W +: W] = keep;
  end
endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR7   = 7'h6E,
  parameter int         SYNC_STAGES = 2,
  parameter int         NREG        = N_REGS,
  parameter int         BASE_ADDR   = FIRST_ADDR
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NREG*8-1:0]  regs_o
);
  localparam int IDXW = $clog2(NREG);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  bus_state_t  state;
  byte_phase_t phase;
  logic [7:0]  shreg, reg_ptr, wr_data;
  logic [3:0]  bitcnt;
  logic        wr_en;
  logic [IDXW-1:0] wr_idx;
  logic        in_range;

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign in_range = ({1'b0, reg_ptr} >= 9'(BASE_ADDR)) &&
                    ({1'b0, reg_ptr} <  9'(BASE_ADDR + NREG));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      phase   <= P_DEV;
      shreg   <= '0;
      bitcnt  <= '0;
      reg_ptr <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= S_RX;
        phase  <= P_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              case (phase)
                P_DEV: begin
                  if (shreg == {DEV_ADDR7, 1'b0}) begin
                    sda_oe <= 1'b1;
                    state  <= S_ACK;
                    phase  <= P_REG;
                  end else begin
                    state <= S_IDLE;
                  end
                end
                P_REG: begin
                  reg_ptr <= shreg;
                  sda_oe  <= 1'b1;
                  state   <= S_ACK;
                  phase   <= P_DAT;
                end
                default: begin
                  if (in_range) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= IDXW'(reg_ptr - 8'(BASE_ADDR));
                    wr_data <= shreg;
                  end
                  sda_oe <= 1'b1;
                  state  <= S_ACK;
                  phase  <= P_REG;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= S_RX;
              bitcnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  i2cw_regbank #(.N(NREG), .W(8), .NIX(NARROW_IDX), .NW(NARROW_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(regs_o)
  );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker
  import i2cw_pkg::*;
#(
  parameter int NREG = N_REGS
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_fall,
  input logic              wr_en,
  input logic              sda_oe,
  input logic [NREG*8-1:0] regs_o
);
  function automatic logic [NREG*8-1:0] defaults();
    logic [NREG*8-1:0] v;
    v = '0;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = reg_default(i);
    v[NARROW_IDX*8 + NARROW_W +: (8 - NARROW_W)] = '0;
    return v;
  endfunction

  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> regs_o == defaults());

  assert_write_acked_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> sda_oe);

  assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_o));

  assert_narrow_upper_R8: assert property (@(posedge clk) disable iff (rst)
    regs_o[NARROW_IDX*8 + NARROW_W +: (8 - NARROW_W)] == '0);

  assert_ack_after_fall_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));
endmodule

bind i2cw_slave i2cw_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .scl_fall(scl_fall), .wr_en(wr_en),
  .sda_oe(sda_oe), .regs_o(regs_o)
);

// File: tb/sim_i2cw_slave.sv
`timescale 1ns/1ps
module sim_i2cw_slave;
  localparam int Q = 20;
  localparam int NR = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs_o;
  logic sda_line;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic oe_seen = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2cw_slave u0 (.clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
                 .sda_oe(sda_oe), .regs_o(regs_o));

  always @(negedge clk) if (sda_oe) oe_seen <= 1'b1;

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      report();
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rg(int a); return regs_o[(a-1)*8 +: 8]; endfunction

  function automatic logic [7:0] dflt(int a);
    case (a)
      1, 3, 4, 5:    return 8'd180;
      6, 10, 11, 12: return 8'h80;
      default:       return 8'h00;
    endcase
  endfunction

  task automatic bstart();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bstop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic bbit(logic b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic sbyte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bbit(b[i]);
    m_sda = 1'b1; wq(); m_scl = 1'b1;
    repeat (Q/2) @(negedge clk);
    ack = sda_oe;
    repeat (Q/2) @(negedge clk);
    m_scl = 1'b0; wq();
  endtask

  task automatic wr_pair(logic [7:0] a, logic [7:0] d, string req);
    logic k;
    sbyte(a, k); chk({req, " addr ack"}, 32'(k), 1);
    sbyte(d, k); chk({req, " data ack"}, 32'(k), 1);
  endtask

  task automatic dev(string req);
    logic k;
    sbyte(8'hDC, k); chk({req, " R2 dev ack"}, 32'(k), 1);
  endtask

  task automatic t_reset();
    for (int a = 1; a <= NR; a++) chk("R1 default", 32'(rg(a)), 32'(dflt(a)));
    chk("R10 idle oe", 32'(sda_oe), 0);
  endtask

  task automatic t_single();
    bstart(); dev("R4"); wr_pair(8'd2, 8'h5A, "R4"); bstop();
    chk("R4 reg2", 32'(rg(2)), 32'h5A);
    bstart(); dev("R5"); wr_pair(8'd8, 8'h12, "R5"); bstop();
    chk("R5 msb first reg8", 32'(rg(8)), 32'h12);
    chk("R10 oe after stop", 32'(sda_oe), 0);
  endtask

  task automatic t_multi();
    bstart(); dev("R6");
    wr_pair(8'd9, 8'h3C, "R6"); wr_pair(8'd10, 8'h11, "R6"); wr_pair(8'd1, 8'h07, "R6");
    bstop();
    chk("R6 reg9", 32'(rg(9)), 32'h3C);
    chk("R6 reg10", 32'(rg(10)), 32'h11);
    chk("R6 reg1", 32'(rg(1)), 32'h07);
    chk("R6 reg11 no increment", 32'(rg(11)), 32'h80);
  endtask

  task automatic t_bad_addr();
    logic k;
    logic [NR*8-1:0] snap;
    snap = regs_o;
    oe_seen = 1'b0;
    bstart(); sbyte(8'hDA, k); sbyte(8'd2, k); sbyte(8'hFF, k); bstop();
    chk("R3 wrong addr no ack", 32'(oe_seen), 0);
    chk("R3 wrong addr regs", 32'(regs_o == snap), 1);
    oe_seen = 1'b0;
    bstart(); sbyte(8'hDD, k); sbyte(8'd3, k); sbyte(8'h01, k); bstop();
    chk("R3 read bit no ack", 32'(oe_seen), 0);
    chk("R3 read bit regs", 32'(regs_o == snap), 1);
  endtask

  task automatic t_unimpl();
    logic [NR*8-1:0] snap;
    snap = regs_o;
    bstart(); dev("R7");
    wr_pair(8'd0, 8'hEE, "R7"); wr_pair(8'd13, 8'hEE, "R7"); wr_pair(8'hFF, 8'hEE, "R7");
    bstop();
    chk("R7 regs unchanged", 32'(regs_o == snap), 1);
  endtask

  task automatic t_narrow();
    bstart(); dev("R8"); wr_pair(8'd7, 8'hFF, "R8"); bstop();
    chk("R8 reg7 masked", 32'(rg(7)), 32'h0F);
  endtask

  task automatic t_abort();
    logic k;
    bstart(); dev("R9"); sbyte(8'd4, k); chk("R9 addr ack", 32'(k), 1);
    bbit(1'b0); bbit(1'b1); bbit(1'b0);
    bstart(); dev("R9"); wr_pair(8'd5, 8'h22, "R9"); bstop();
    chk("R9 aborted reg4", 32'(rg(4)), 32'd180);
    chk("R9 following reg5", 32'(rg(5)), 32'h22);
    bstart(); dev("R9"); sbyte(8'd3, k); bstop();
    chk("R9 stop before data reg3", 32'(rg(3)), 32'd180);
    chk("R10 oe after stop", 32'(sda_oe), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_bad_addr();
    t_unimpl();
    t_narrow();
    t_abort();
    if (!done) begin
      done = 1'b1;
      report();
    end
  end
endmodule